// File: doc/BRIEF.md
# Single-Level Page Translation Unit

This unit turns 16-bit virtual addresses into 15-bit physical addresses. It uses an internal table of 16 page descriptors, one for each 4 KB virtual page. The top four address bits select a descriptor. If that page is resident and the access type is permitted, the descriptor's 3-bit frame number is placed above the unchanged 12-bit offset. The page's uncached flag is returned with the address. Each successful access marks its page as referenced, and a successful write also marks it as modified.

An access to a non-resident page raises a page fault. An access the page's permissions forbid raises a protection fault. Either fault reports the virtual page and whether the access was a write, and no descriptor changes. The operating system loads whole descriptors through a write port and can wipe every referenced flag at once. A combinational inspect port lets it read a page's modified and referenced flags when it chooses a victim. Every request gets exactly one registered outcome one cycle later.

Top module: `page_xlate_unit`

## Requirements
- R1: After reset every descriptor is non-resident with its modified and referenced flags clear, and no response or fault output is asserted.
- R2: A request accepted at a clock edge produces its outcome exactly one cycle later, for one cycle. On success, `resp_valid` is 1 and `resp_paddr` equals {frame number, virtual address bits 11:0}.
- R3: A request to a page whose resident flag is 0 gives `pf_fault`=1 and `resp_valid`=0. This holds whatever that page's permissions are, so a page fault takes priority over a protection fault.
- R4: A read to a resident page needs its read-permit flag, and a write needs its write-permit flag. A violation gives `prot_fault`=1 and `resp_valid`=0.
- R5: A successful access sets the page's referenced flag, and a successful write also sets its modified flag. A read leaves the modified flag as it was.
- R6: A faulting access leaves the modified and referenced flags of every page unchanged.
- R7: On either fault, `fault_vpn` holds virtual address bits 15:12 of the request and `fault_write` holds its write flag (1 = write).
- R8: On success, `resp_uncached` equals the page's uncached flag.
- R9: With `tbl_we`=1, all fields of descriptor `tbl_idx` are loaded at that edge, and a request in the next cycle sees them.
- R10: `ref_clear`=1 clears the referenced flag of every page at that edge and leaves the modified flags unchanged.
- R11: A cycle without a request produces no response and no fault in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request |
| req_vaddr | input | 16 | Virtual address |
| req_write | input | 1 | 1 = write access, 0 = read |
| resp_valid | output | 1 | Translation succeeded |
| resp_paddr | output | 15 | Physical address |
| resp_uncached | output | 1 | Page must bypass caches |
| pf_fault | output | 1 | Page not resident |
| prot_fault | output | 1 | Access type not permitted |
| fault_vpn | output | 4 | Virtual page of the faulting access |
| fault_write | output | 1 | Faulting access was a write |
| tbl_we | input | 1 | Load a descriptor |
| tbl_idx | input | 4 | Descriptor to load |
| tbl_pfn | input | 3 | Frame number to load |
| tbl_present | input | 1 | Resident flag to load |
| tbl_rd_ok | input | 1 | Read-permit flag to load |
| tbl_wr_ok | input | 1 | Write-permit flag to load |
| tbl_modified | input | 1 | Modified flag to load |
| tbl_referenced | input | 1 | Referenced flag to load |
| tbl_nocache | input | 1 | Uncached flag to load |
| ref_clear | input | 1 | Clear all referenced flags |
| insp_idx | input | 4 | Descriptor to inspect |
| insp_modified | output | 1 | Modified flag of the inspected descriptor |
| insp_referenced | output | 1 | Referenced flag of the inspected descriptor |

## Verification
Directed cases come first. They cover an access to an absent page, an absent page with full permissions accessed by a write (to show fault priority), a read-only page hit by both a read and a write, and a referenced-flag wipe after which the modified flags must survive. A long seeded random stream then mixes reads, writes, descriptor loads, wipes and idle cycles across all 16 pages. This separates a wrong offset or frame splice, a swapped fault kind, a status flag that is set on a fault or on the wrong access type, and a wipe that touches the modified flags. After each step the inspect port is pointed at the page that was touched, so any status flag update that should not happen shows up at the ports.

// File: rtl/page_xlate_unit.sv
module page_xlate_unit #(
  parameter int VA_W  = 16,
  parameter int OFS_W = 12,
  parameter int PFN_W = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  input  logic [VA_W-1:0]        req_vaddr,
  input  logic                   req_write,
  output logic                   resp_valid,
  output logic [PFN_W+OFS_W-1:0] resp_paddr,
  output logic                   resp_uncached,
  output logic                   pf_fault,
  output logic                   prot_fault,
  output logic [VA_W-OFS_W-1:0]  fault_vpn,
  output logic                   fault_write,
  input  logic                   tbl_we,
  input  logic [VA_W-OFS_W-1:0]  tbl_idx,
  input  logic [PFN_W-1:0]       tbl_pfn,
  input  logic                   tbl_present,
  input  logic                   tbl_rd_ok,
  input  logic                   tbl_wr_ok,
  input  logic                   tbl_modified,
  input  logic                   tbl_referenced,
  input  logic                   tbl_nocache,
  input  logic                   ref_clear,
  input  logic [VA_W-OFS_W-1:0]  insp_idx,
  output logic                   insp_modified,
  output logic                   insp_referenced
);
  localparam int VPN_W   = VA_W - OFS_W;
  localparam int ENTRIES = 1 << VPN_W;
  localparam int PA_W    = PFN_W + OFS_W;

  logic [PFN_W-1:0]   pfn_q [ENTRIES];
  logic [ENTRIES-1:0] pres_q, rd_q, wr_q, mod_q, ref_q, nc_q;

  wire [VPN_W-1:0] vpn     = req_vaddr[VA_W-1:OFS_W];
  wire             absent  = !pres_q[vpn];
  wire             perm_ok = req_write ? wr_q[vpn] : rd_q[vpn];
  wire             go      = req_valid && !absent && perm_ok;

  assign insp_modified   = mod_q[insp_idx];
  assign insp_referenced = ref_q[insp_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pres_q <= '0;
      rd_q   <= '0;
      wr_q   <= '0;
      mod_q  <= '0;
      ref_q  <= '0;
      nc_q   <= '0;
      for (int i = 0; i < ENTRIES; i++) pfn_q[i] <= '0;
    end else begin
      if (ref_clear) ref_q <= '0;
      if (go) begin
        ref_q[vpn] <= 1'b1;
        if (req_write) mod_q[vpn] <= 1'b1;
      end
      if (tbl_we) begin
        pfn_q[tbl_idx]  <= tbl_pfn;
        pres_q[tbl_idx] <= tbl_present;
        rd_q[tbl_idx]   <= tbl_rd_ok;
        wr_q[tbl_idx]   <= tbl_wr_ok;
        mod_q[tbl_idx]  <= tbl_modified;
        ref_q[tbl_idx]  <= tbl_referenced;
        nc_q[tbl_idx]   <= tbl_nocache;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      resp_valid    <= 1'b0;
      resp_paddr    <= '0;
      resp_uncached <= 1'b0;
      pf_fault      <= 1'b0;
      prot_fault    <= 1'b0;
      fault_vpn     <= '0;
      fault_write   <= 1'b0;
    end else begin
      resp_valid    <= go;
      pf_fault      <= req_valid && absent;
      prot_fault    <= req_valid && !absent && !perm_ok;
      resp_paddr    <= go ? {pfn_q[vpn], req_vaddr[OFS_W-1:0]} : '0;
      resp_uncached <= go && nc_q[vpn];
      if (req_valid && !go) begin
        fault_vpn   <= vpn;
        fault_write <= req_write;
      end
    end
  end

  // R2
  one_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> $countones({resp_valid, pf_fault, prot_fault}) == 1);
  // R11
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !resp_valid && !pf_fault && !prot_fault);
  // R2
  offset_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> resp_paddr[OFS_W-1:0] == $past(req_vaddr[OFS_W-1:0]));
  // R7
  fault_vpn_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pf_fault || prot_fault) |-> fault_vpn == $past(req_vaddr[VA_W-1:OFS_W]));
  // R6
  fault_no_mod_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !go && !tbl_we) |=> $stable(mod_q));
  // R10
  wipe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_clear && !req_valid && !tbl_we) |=> ref_q == '0 && $stable(mod_q));
endmodule

// File: tb/page_xlate_unit_tb_top.sv
module page_xlate_unit_tb_top;
  logic clk = 0, rst_n = 0;
  always #10 clk = ~clk;

  logic req_valid = 0, req_write = 0, tbl_we = 0, ref_clear = 0;
  logic [15:0] req_vaddr = 0;
  logic [3:0] tbl_idx = 0, insp_idx = 0;
  logic [2:0] tbl_pfn = 0;
  logic tbl_present = 0, tbl_rd_ok = 0, tbl_wr_ok = 0, tbl_modified = 0, tbl_referenced = 0, tbl_nocache = 0;
  logic resp_valid, resp_uncached, pf_fault, prot_fault, fault_write, insp_modified, insp_referenced;
  logic [14:0] resp_paddr;
  logic [3:0] fault_vpn;

  page_xlate_unit dut_i (.*);

  int total = 0, fails = 0;
  bit finished = 0;
  logic [2:0] m_pfn [16];
  logic [15:0] m_pres, m_rd, m_wr, m_mod, m_ref, m_nc;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [1:0] outcome(input logic [3:0] v, input bit w);
    if (!m_pres[v]) return 2'd1;
    if (w ? !m_wr[v] : !m_rd[v]) return 2'd2;
    return 2'd3;
  endfunction

  task automatic cyc(input bit rv, input logic [15:0] va, input bit wr,
                     input bit we, input logic [3:0] wi, input logic [2:0] wp,
                     input logic [5:0] wf, input bit clr);
    logic [3:0] v = va[15:12];
    logic [1:0] oc = rv ? outcome(v, wr) : 2'd0;
    logic [14:0] epa = {m_pfn[v], va[11:0]};
    bit enc = m_nc[v];
    req_valid = rv; req_vaddr = va; req_write = wr; ref_clear = clr;
    tbl_we = we; tbl_idx = wi; tbl_pfn = wp;
    {tbl_present, tbl_rd_ok, tbl_wr_ok, tbl_modified, tbl_referenced, tbl_nocache} = wf;
    insp_idx = we ? wi : v;
    if (clr) m_ref = '0;
    if (oc == 2'd3) begin m_ref[v] = 1; if (wr) m_mod[v] = 1; end
    if (we) begin
      m_pfn[wi] = wp;
      {m_pres[wi], m_rd[wi], m_wr[wi], m_mod[wi], m_ref[wi], m_nc[wi]} = wf;
    end
    @(negedge clk);
    case (oc)
      2'd0: chk(!resp_valid && !pf_fault && !prot_fault, "R11 idle", {resp_valid, pf_fault, prot_fault}, 0);
      2'd1: begin
        chk(pf_fault && !resp_valid && !prot_fault, "R3 page fault", {resp_valid, pf_fault, prot_fault}, 3'b010);
        chk(fault_vpn == v && fault_write == wr, "R7 fault info", {fault_vpn, fault_write}, {v, wr});
      end
      2'd2: begin
        chk(prot_fault && !resp_valid && !pf_fault, "R4 prot fault", {resp_valid, pf_fault, prot_fault}, 3'b001);
        chk(fault_vpn == v && fault_write == wr, "R7 fault info", {fault_vpn, fault_write}, {v, wr});
      end
      default: begin
        chk(resp_valid && !pf_fault && !prot_fault && resp_paddr == epa, "R2 translate",
            {resp_valid, resp_paddr}, {1'b1, epa});
        chk(resp_uncached == enc, "R8 uncached", resp_uncached, enc);
      end
    endcase
    chk(insp_modified == m_mod[insp_idx] && insp_referenced == m_ref[insp_idx],
        (oc == 1 || oc == 2) ? "R6 flags after fault" : (clr ? "R10 wipe" : "R5 status flags"),
        {insp_modified, insp_referenced}, {m_mod[insp_idx], m_ref[insp_idx]});
    req_valid = 0; tbl_we = 0; ref_clear = 0;
  endtask

  initial begin
    #(20 * 150000);
    if (!finished) begin
      chk(0, "watchdog", 0, 1);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 16; i++) m_pfn[i] = 0;
    {m_pres, m_rd, m_wr, m_mod, m_ref, m_nc} = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    for (int i = 0; i < 16; i++) begin
      insp_idx = i[3:0];
      #1 chk(!insp_modified && !insp_referenced && !resp_valid && !pf_fault && !prot_fault,
             "R1 reset", {insp_modified, insp_referenced, resp_valid}, 0);
    end
    @(negedge clk);
    cyc(1, 16'h3ABC, 0, 0, 0, 0, 0, 0);                  // R1 absent after reset
    cyc(0, 0, 0, 1, 4'd3, 3'd5, 6'b110001, 0);           // R9 load read-only uncached
    cyc(1, 16'h3ABC, 0, 0, 0, 0, 0, 0);                  // R9 R2 R8 R5
    cyc(1, 16'h3123, 1, 0, 0, 0, 0, 0);                  // R4 write to read-only
    cyc(0, 0, 0, 1, 4'd0, 3'd7, 6'b011000, 0);           // absent, full permissions
    cyc(1, 16'h0FFF, 1, 0, 0, 0, 0, 0);                  // R3 priority over R4
    cyc(0, 0, 0, 1, 4'd15, 3'd2, 6'b101000, 0);          // write-only page
    cyc(1, 16'hF000, 0, 0, 0, 0, 0, 0);                  // R4 read refused
    cyc(1, 16'hF001, 1, 0, 0, 0, 0, 0);                  // R5 write sets modified
    cyc(0, 16'hF000, 0, 0, 0, 0, 0, 1);                  // R10 wipe keeps modified
    cyc(0, 0, 0, 0, 0, 0, 0, 0);                         // R11
    void'($urandom(32'h5EED));
    for (int n = 0; n < 4000; n++) begin
      int k = $urandom_range(0, 9);
      logic [15:0] va = 16'($urandom);
      if (k < 6) cyc(1, va, 1'($urandom), 0, 0, 0, 0, 0);
      else if (k < 8) cyc(0, va, 0, 1, 4'($urandom), 3'($urandom),
                          6'($urandom) | {($urandom_range(0, 3) != 0), 5'b0}, 0);
      else if (k == 8) cyc(0, va, 0, 0, 0, 0, 0, ($urandom_range(0, 3) == 0));
      else cyc(1, va, 1'($urandom), 0, 0, 0, 0, ($urandom_range(0, 1) == 0));
    end
    finished = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule